// File: doc/BRIEF.md
# Four-Way Interleaved Speculative Decision Selector

This block is the digital back end of a one-tap decision-feedback equalizer whose receive path is split into four interleaved lanes. Each lane owns one symbol out of every four consecutive symbols. For its symbol, a lane gets two comparator results each cycle. One was taken against a threshold raised by the feedback weight h1, and the other against a threshold lowered by h1. The block latches both results. It then resolves the true decision of each lane from the decision for the symbol just before it, and delivers four recovered bits per cycle in symbol order.

The lanes are chained. Lane 1 is steered by lane 0, lane 2 by lane 1, and lane 3 by lane 2, all inside one cycle. Lane 0 is steered by the lane 3 decision of the previous valid word, which the block keeps as history. The block also holds the threshold setting that drives the analog comparator references: a 7-bit magnitude code and a polarity bit.

Top module: `dfe_unroll_sel`

## Requirements
- R1: In the cycle after a synchronous reset, `dec_valid` is 0, `dec_word` is 0, `thr_code` is 0 and `thr_neg` is 0.
- R2: A word sampled with `smp_valid` high appears on `dec_word` with `dec_valid` high exactly two clock edges later (input latch, then output register).
- R3: For lanes 1 to 3, bit k of the output word equals `smp_hi[k]` if bit k−1 of the same word is 1, and `smp_lo[k]` if it is 0.
- R4: Bit 0 of a word is chosen by bit 3 of the previous valid word: `smp_hi[0]` when that bit is 1, `smp_lo[0]` when it is 0. Right after reset, this history bit is 0.
- R5: Bit 0 of `dec_word` is the earliest symbol and bit 3 the latest. Bit k comes from `smp_hi[k]` or `smp_lo[k]`.
- R6: Cycles with `smp_valid` low produce no `dec_valid` pulse and leave the history bit unchanged, so the next valid word uses the bit 3 of the last valid word.
- R7: When `cfg_we` is high at a clock edge, `thr_code` takes `cfg_code` and `thr_neg` takes `cfg_neg` (1 selects the negative polarity). While `cfg_we` is low, both hold their values whatever `cfg_code` and `cfg_neg` do.
- R8: While `dec_valid` is low, `dec_word` keeps the last decided word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Load strobe for the threshold setting |
| cfg_code | input | 7 | New threshold magnitude code |
| cfg_neg | input | 1 | New threshold polarity, 1 = negative |
| thr_code | output | 7 | Held threshold magnitude code |
| thr_neg | output | 1 | Held threshold polarity |
| smp_valid | input | 1 | Comparator results on smp_hi/smp_lo are valid |
| smp_hi | input | 4 | Per-lane result against the +h1 threshold |
| smp_lo | input | 4 | Per-lane result against the −h1 threshold |
| dec_valid | output | 1 | dec_word carries a new decided word |
| dec_word | output | 4 | Decided bits, bit 0 earliest symbol |

## Verification
The assertions assume that comparator results are meaningful only in cycles where `smp_valid` is high. They also assume that the history bit moves only with valid words. The stimulus therefore mixes back-to-back valid words with idle gaps, and on idle cycles it drives changing values on the comparator inputs. The threshold register is exercised with its configuration inputs changing while `cfg_we` is low. This shows that any load outside a strobe would be visible on the outputs.

// File: rtl/dfe_sel_pkg.sv
package dfe_sel_pkg;

    localparam int unsigned LANES_DEF  = 4;
    localparam int unsigned CODE_W_DEF = 7;

    typedef enum logic {
        POL_POS = 1'b0,
        POL_NEG = 1'b1
    } thr_pol_e;

    // Pick the speculative result that matches the earlier decision.
    function automatic logic spec_pick(input logic prev_bit,
                                       input logic above_pos,
                                       input logic above_neg);
        return prev_bit ? above_pos : above_neg;
    endfunction

endpackage

// File: rtl/dfe_thr_reg.sv
module dfe_thr_reg
    import dfe_sel_pkg::*;
#(
    parameter int unsigned CODE_W = CODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CODE_W-1:0] code_in,
    input  logic              neg_in,
    output logic [CODE_W-1:0] code_q,
    output thr_pol_e          pol_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            pol_q  <= POL_POS;
        end else if (we) begin
            code_q <= code_in;
            pol_q  <= neg_in ? POL_NEG : POL_POS;
        end
    end

    a_r7_hold_code: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(code_q) && $stable(pol_q));

    a_r7_load_code: assert property (@(posedge clk) disable iff (rst)
        we |=> code_q == $past(code_in));

endmodule

// File: rtl/dfe_spec_latch.sv
module dfe_spec_latch
    import dfe_sel_pkg::*;
#(
    parameter int unsigned LANES = LANES_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [LANES-1:0] in_hi,
    input  logic [LANES-1:0] in_lo,
    output logic             q_valid,
    output logic [LANES-1:0] q_hi,
    output logic [LANES-1:0] q_lo
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_hi    <= '0;
            q_lo    <= '0;
        end else begin
            q_valid <= in_valid;
            if (in_valid) begin
                q_hi <= in_hi;
                q_lo <= in_lo;
            end
        end
    end

endmodule

// File: rtl/dfe_select_chain.sv
module dfe_select_chain
    import dfe_sel_pkg::*;
#(
    parameter int unsigned LANES = LANES_DEF
) (
    input  logic             hist_bit,
    input  logic [LANES-1:0] above_pos,
    input  logic [LANES-1:0] above_neg,
    output logic [LANES-1:0] bits
);

    logic [LANES:0] steer;

    assign steer[0] = hist_bit;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign bits[k]    = spec_pick(steer[k], above_pos[k], above_neg[k]);
        assign steer[k+1] = bits[k];
    end

endmodule

// File: rtl/dfe_unroll_sel.sv
module dfe_unroll_sel
    import dfe_sel_pkg::*;
#(
    parameter int unsigned LANES  = LANES_DEF,
    parameter int unsigned CODE_W = CODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CODE_W-1:0] cfg_code,
    input  logic              cfg_neg,
    output logic [CODE_W-1:0] thr_code,
    output logic              thr_neg,
    input  logic              smp_valid,
    input  logic [LANES-1:0]  smp_hi,
    input  logic [LANES-1:0]  smp_lo,
    output logic              dec_valid,
    output logic [LANES-1:0]  dec_word
);

    localparam int unsigned LAST = LANES - 1;

    thr_pol_e         pol_q;
    logic             lat_valid;
    logic [LANES-1:0] lat_hi;
    logic [LANES-1:0] lat_lo;
    logic [LANES-1:0] chain_bits;
    logic             hist_q;

    dfe_thr_reg #(.CODE_W(CODE_W)) u_thr (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .code_in (cfg_code),
        .neg_in  (cfg_neg),
        .code_q  (thr_code),
        .pol_q   (pol_q)
    );

    assign thr_neg = (pol_q == POL_NEG);

    dfe_spec_latch #(.LANES(LANES)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .in_valid (smp_valid),
        .in_hi    (smp_hi),
        .in_lo    (smp_lo),
        .q_valid  (lat_valid),
        .q_hi     (lat_hi),
        .q_lo     (lat_lo)
    );

    dfe_select_chain #(.LANES(LANES)) u_chain (
        .hist_bit  (hist_q),
        .above_pos (lat_hi),
        .above_neg (lat_lo),
        .bits      (chain_bits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q    <= 1'b0;
            dec_valid <= 1'b0;
            dec_word  <= '0;
        end else begin
            dec_valid <= lat_valid;
            if (lat_valid) begin
                hist_q   <= chain_bits[LAST];
                dec_word <= chain_bits;
            end
        end
    end

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !dec_valid && dec_word == '0);

    a_r2_two_edge_latency: assert property (@(posedge clk) disable iff (rst)
        smp_valid && !$past(rst) |=> lat_valid);

    a_r4_lane0_history: assert property (@(posedge clk) disable iff (rst)
        dec_valid && !$past(rst) |->
            dec_word[0] == ($past(hist_q) ? $past(lat_hi[0]) : $past(lat_lo[0])));

    a_r6_history_hold: assert property (@(posedge clk) disable iff (rst)
        !lat_valid |=> $stable(hist_q));

    a_r8_word_hold: assert property (@(posedge clk) disable iff (rst)
        !lat_valid |=> $stable(dec_word) && !dec_valid);

    for (genvar k = 1; k < LANES; k++) begin : g_chk
        a_r3_lane_steer: assert property (@(posedge clk) disable iff (rst)
            dec_valid && !$past(rst) |->
                dec_word[k] == (dec_word[k-1] ? $past(lat_hi[k]) : $past(lat_lo[k])));
    end

endmodule

// File: tb/dfe_unroll_sel_test.sv
module dfe_unroll_sel_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [6:0] cfg_code = '0;
    logic       cfg_neg = 1'b0;
    logic [6:0] thr_code;
    logic       thr_neg;
    logic       smp_valid = 1'b0;
    logic [3:0] smp_hi = '0;
    logic [3:0] smp_lo = '0;
    logic       dec_valid;
    logic [3:0] dec_word;

    int n_cmp = 0;
    int n_bad = 0;
    logic [3:0] exp_q[$];
    logic       model_hist = 1'b0;
    logic [3:0] last_exp = '0;
    logic [15:0] lfsr = 16'hACE1;
    bit done = 0;

    always #2.5 clk = ~clk;

    dfe_unroll_sel uut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_code(cfg_code), .cfg_neg(cfg_neg),
        .thr_code(thr_code), .thr_neg(thr_neg),
        .smp_valid(smp_valid), .smp_hi(smp_hi), .smp_lo(smp_lo),
        .dec_valid(dec_valid), .dec_word(dec_word)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Driver: R3 R4 R5 reference model pushes the expected word.
    task automatic send(input logic [3:0] hi, input logic [3:0] lo);
        logic [3:0] w;
        logic       s;
        @(posedge clk); #1;
        smp_valid = 1'b1; smp_hi = hi; smp_lo = lo;
        s = model_hist;
        for (int k = 0; k < 4; k++) begin
            w[k] = s ? hi[k] : lo[k];
            s = w[k];
        end
        model_hist = w[3];
        last_exp = w;
        exp_q.push_back(w);
    endtask

    // R6: idle cycles carry junk on the comparator inputs.
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            smp_valid = 1'b0; smp_hi = lfsr[3:0]; smp_lo = lfsr[7:4];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end
    endtask

    // Monitor: pops and compares each decided word (R2 R3 R4 R5 R6).
    always @(negedge clk) begin
        if (!rst && !done && dec_valid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected dec_valid", 1, 0);
            end else begin
                check("R3 R4 R5 decided word", int'(dec_word), int'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 dec_valid", int'(dec_valid), 0);
        check("R1 dec_word", int'(dec_word), 0);
        check("R1 thr_code", int'(thr_code), 0);
        check("R1 thr_neg", int'(thr_neg), 0);

        // R7 load then hold
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_code = 7'h55; cfg_neg = 1'b1;
        @(posedge clk); #1;
        cfg_we = 1'b0; cfg_code = 7'h2A; cfg_neg = 1'b0;
        @(negedge clk);
        check("R7 thr_code load", int'(thr_code), 'h55);
        check("R7 thr_neg load", int'(thr_neg), 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 thr_code hold", int'(thr_code), 'h55);
        check("R7 thr_neg hold", int'(thr_neg), 1);

        // R4: first word after reset steered by history 0
        send(4'hF, 4'h0);
        send(4'hF, 4'hF);
        send(4'h0, 4'hF);
        send(4'hA, 4'h5);
        idle(3);
        @(negedge clk);
        check("R8 word held", int'(dec_word), int'(last_exp));
        check("R8 dec_valid low", int'(dec_valid), 0);

        // R6: history survives idle gaps
        send(4'h0, 4'h1);
        idle(2);
        send(4'h3, 4'hC);
        idle(1);
        for (int i = 0; i < 60; i++) begin
            send(lfsr[3:0], lfsr[11:8]);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[0]) idle(int'(lfsr[2:1]));
        end
        idle(4);
        @(negedge clk);
        check("R2 queue drained", exp_q.size(), 0);
        check("R8 final word held", int'(dec_word), int'(last_exp));

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule